// File: doc/BRIEF.md
# Phase-Correct PWM Timer with Compare Flag

The block is an up/down timer/counter that generates a symmetric pulse-width-modulated waveform on one output. It runs on the single system clock. A prescaler produces a tick enable that either fires on every clock or on every eighth clock. The counter moves by one step on each tick. It climbs from zero to a selectable top value and then falls back to zero. It turns around at each end without holding the end value for a second tick.

Software writes a compare value into a holding register. That value becomes active only when the counter sits at its top value. The top value is either the all-ones count or the active compare value. A two-bit output mode selects one of four behaviours for the output: forced low, toggle on each match, non-inverted PWM or inverted PWM. A sticky flag records every compare match and is cleared through a dedicated input. The counter value is brought out so that the flag timing and the waveform phase can be observed.

Top module: `pcpwm_timer`

## Requirements
- R1: While and after reset, `cnt_o` is 0, `pwm_o` is 0 and `flag_o` is 0 until a tick changes them.
- R2: On each tick the counter moves by exactly one. It counts up from 0 to TOP and then down to 0, with the sequence 0,1,..,TOP,TOP-1,..,1,0,1,.. so that neither end value repeats. With `top_sel_i`=0, TOP is 2^W-1.
- R3: With `top_sel_i`=1, TOP is the active compare value, and the counter never exceeds it once that value is loaded.
- R4: With `presc_sel_i`=0 a tick occurs on every clock edge. With `presc_sel_i`=1 a tick occurs on every eighth edge, and the first step after reset release happens on the eighth rising edge.
- R5: A pulse on `cmp_wr_i` stores `cmp_wdata_i` in a holding register only. The active compare value takes the held value on the tick where the counter equals TOP, and matches use the old value until then.
- R6: `flag_o` rises on the clock edge of the tick on which the counter leaves the compare value, which is the same edge where `cnt_o` moves away from it. With `presc_sel_i`=1 it does not rise on any earlier edge.
- R7: `flag_o` stays set until `flag_clr_i` is high at a clock edge. If a match and a clear fall on the same edge, the flag stays set.
- R8: Mode encoding on `mode_i`: 0 = output forced low, 1 = toggle on match, 2 = non-inverted PWM, 3 = inverted PWM.
- R9: In non-inverted mode the output goes low when the counter leaves the compare value C while counting up, and goes high when it leaves C while counting down. For 0<C<TOP this gives 2*C high ticks in each 2*TOP-tick period.
- R10: In non-inverted mode a compare value of 0 holds the output low for the whole period, and a compare value equal to TOP holds it high for the whole period.
- R11: Inverted mode drives the complement of the non-inverted waveform, including both extreme compare values.
- R12: In toggle mode the output inverts on every match. With `top_sel_i`=1 this gives a 50% duty square wave with a period of 4*TOP ticks.
- R13: In mode 0 `pwm_o` stays low whatever the counter and compare values are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_sel_i | input | 1 | Tick rate: 0 = every clock, 1 = every eighth clock |
| top_sel_i | input | 1 | Top value: 0 = all ones, 1 = active compare value |
| mode_i | input | 2 | Output mode (see R8) |
| cmp_wr_i | input | 1 | Write strobe for the compare holding register |
| cmp_wdata_i | input | W | Compare value to hold |
| flag_clr_i | input | 1 | Clears the compare flag |
| cnt_o | output | W | Current counter value |
| pwm_o | output | 1 | Waveform output |
| flag_o | output | 1 | Sticky compare-match flag |

## Verification
The hardest case to reach is the buffered compare update. Its effect shows only on the match pattern after the next top turnaround, so the bench writes a new value in the middle of an up-count and watches the flag. The flag must stay low as the counter crosses the new value on the way up and then set as the counter crosses it on the way down. A second hard case is the flag under the divide-by-eight prescaler. The bench finds the first clock where the counter shows the compare value, then checks the flag on each of the following seven edges and sees it set only on the eighth. A third is a clear that coincides with a match. The bench raises the clear on exactly the clock where the counter sits on the compare value.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;
  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_NONINV = 2'd2,
    OM_INV    = 2'd3
  } out_mode_e;

  localparam int unsigned SLOW_DIV = 8;
endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pcnt_q <= '0;
    else if (pcnt_q == LAST)  pcnt_q <= '0;
    else                      pcnt_q <= pcnt_q + PW'(1);
  end

  assign tick_o = slow_i ? (pcnt_q == LAST) : 1'b1;
endmodule

// File: rtl/pcpwm_counter.sv
module pcpwm_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         up_o,
  output logic         at_top_o
);
  logic [W-1:0] cnt_q;
  logic         dir_q;
  logic         up_step;

  // direction of the step taken on the next tick; ends turn around
  always_comb begin
    if (cnt_q == '0)          up_step = 1'b1;
    else if (cnt_q >= top_i)  up_step = 1'b0;
    else                      up_step = dir_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (tick_i) begin
      if (top_i == '0) begin
        cnt_q <= '0;
        dir_q <= 1'b1;
      end else begin
        cnt_q <= up_step ? cnt_q + W'(1) : cnt_q - W'(1);
        dir_q <= up_step;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign up_o     = up_step;
  assign at_top_o = (cnt_q == top_i);
endmodule

// File: rtl/pcpwm_compare.sv
module pcpwm_compare
  import pcpwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  input  logic         up_i,
  input  logic         at_top_i,
  input  logic [W-1:0] top_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  input  out_mode_e    mode_i,
  output logic [W-1:0] ocr_act_o,
  output logic         flag_o,
  output logic         pwm_o
);
  logic [W-1:0] ocr_buf_q, ocr_act_q;
  logic         flag_q, lvl_q, tog_q;
  logic         match;

  assign match = tick_i && (cnt_i == ocr_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocr_buf_q <= '0;
      ocr_act_q <= '0;
    end else begin
      if (wr_i)               ocr_buf_q <= wdata_i;
      if (tick_i && at_top_i) ocr_act_q <= ocr_buf_q;
    end
  end

  // match wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (match)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  // non-inverted level; extremes forced so the output never glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
    end else if (tick_i) begin
      if (ocr_act_q == '0)         lvl_q <= 1'b0;
      else if (ocr_act_q >= top_i) lvl_q <= 1'b1;
      else if (match)              lvl_q <= !up_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tog_q <= 1'b0;
    else if (match)  tog_q <= !tog_q;
  end

  always_comb begin
    unique case (mode_i)
      OM_TOGGLE: pwm_o = tog_q;
      OM_NONINV: pwm_o = lvl_q;
      OM_INV:    pwm_o = !lvl_q;
      default:   pwm_o = 1'b0;
    endcase
  end

  assign ocr_act_o = ocr_act_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
  import pcpwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         presc_sel_i,
  input  logic         top_sel_i,
  input  logic [1:0]   mode_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_wdata_i,
  input  logic         flag_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         pwm_o,
  output logic         flag_o
);
  localparam logic [W-1:0] TOP_MAX = {W{1'b1}};

  logic         tick;
  logic [W-1:0] ocr_act;
  logic [W-1:0] top_val;
  logic         step_up, at_top;

  assign top_val = top_sel_i ? ocr_act : TOP_MAX;

  pcpwm_prescaler #(.DIV(SLOW_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slow_i (presc_sel_i),
    .tick_o (tick)
  );

  pcpwm_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .top_i    (top_val),
    .cnt_o    (cnt_o),
    .up_o     (step_up),
    .at_top_o (at_top)
  );

  pcpwm_compare #(.W(W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .cnt_i     (cnt_o),
    .up_i      (step_up),
    .at_top_i  (at_top),
    .top_i     (top_val),
    .wr_i      (cmp_wr_i),
    .wdata_i   (cmp_wdata_i),
    .clr_i     (flag_clr_i),
    .mode_i    (out_mode_e'(mode_i)),
    .ocr_act_o (ocr_act),
    .flag_o    (flag_o),
    .pwm_o     (pwm_o)
  );
endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick,
  input logic         top_sel_i,
  input logic [1:0]   mode_i,
  input logic         flag_clr_i,
  input logic [W-1:0] ocr_act,
  input logic [W-1:0] cnt_o,
  input logic         pwm_o,
  input logic         flag_o
);
  logic [W-1:0] top_c;
  assign top_c = top_sel_i ? ocr_act : {W{1'b1}};

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && top_c != '0) |=> (cnt_o == $past(cnt_o) + W'(1)) || (cnt_o == $past(cnt_o) - W'(1))); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt_o)); // R4

  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick || cnt_o != top_c) |=> $stable(ocr_act)); // R5

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_o == ocr_act) |=> flag_o); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o); // R7

  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |-> !pwm_o); // R13
endmodule

bind pcpwm_timer pcpwm_timer_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick       (tick),
  .top_sel_i  (top_sel_i),
  .mode_i     (mode_i),
  .flag_clr_i (flag_clr_i),
  .ocr_act    (ocr_act),
  .cnt_o      (cnt_o),
  .pwm_o      (pwm_o),
  .flag_o     (flag_o)
);

// File: tb/pcpwm_timer_test.sv
`timescale 1ns/1ps
module pcpwm_timer_test;
  localparam int unsigned W = 4;
  localparam int TOPM = (1 << W) - 1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         presc_sel_i = 1'b0;
  logic         top_sel_i = 1'b0;
  logic [1:0]   mode_i = 2'd0;
  logic         cmp_wr_i = 1'b0;
  logic [W-1:0] cmp_wdata_i = '0;
  logic         flag_clr_i = 1'b0;
  logic [W-1:0] cnt_o;
  logic         pwm_o;
  logic         flag_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pcpwm_timer #(.W(W)) uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .presc_sel_i (presc_sel_i),
    .top_sel_i   (top_sel_i),
    .mode_i      (mode_i),
    .cmp_wr_i    (cmp_wr_i),
    .cmp_wdata_i (cmp_wdata_i),
    .flag_clr_i  (flag_clr_i),
    .cnt_o       (cnt_o),
    .pwm_o       (pwm_o),
    .flag_o      (flag_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit presc, input bit tsel, input logic [1:0] mode);
    rst_ni = 1'b0;
    presc_sel_i = presc;
    top_sel_i = tsel;
    mode_i = mode;
    cmp_wr_i = 1'b0;
    flag_clr_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // reset, write compare value, wait until it is active
  task automatic setup(input bit presc, input bit tsel, input logic [1:0] mode, input int cval);
    do_reset(presc, tsel, mode);
    cmp_wr_i = 1'b1;
    cmp_wdata_i = W'(cval);
    @(negedge clk_i);
    cmp_wr_i = 1'b0;
    if (!tsel) begin
      while (int'(cnt_o) != TOPM) @(negedge clk_i);
      while (int'(cnt_o) == TOPM) @(negedge clk_i);
    end else begin
      repeat (20) @(negedge clk_i);
    end
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    @(negedge clk_i);
    flag_clr_i = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    while (int'(cnt_o) != v) @(negedge clk_i);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(cnt_o == '0, "R1 cnt in reset", int'(cnt_o), 0);
    chk(pwm_o == 1'b0, "R1 pwm in reset", int'(pwm_o), 0);
    chk(flag_o == 1'b0, "R1 flag in reset", int'(flag_o), 0);
  endtask

  task automatic t_triangle();
    do_reset(1'b0, 1'b0, 2'd2);
    for (int t = 0; t < 32; t++) begin
      int e;
      e = (t <= TOPM) ? t : ((t <= 2 * TOPM) ? 2 * TOPM - t : t - 2 * TOPM);
      chk(int'(cnt_o) == e, "R2 triangle count", int'(cnt_o), e);
      @(negedge clk_i);
    end
  endtask

  task automatic t_prescale();
    int bad = 0;
    do_reset(1'b1, 1'b0, 2'd2);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk_i);
      if (cnt_o != '0) bad++;
    end
    chk(bad == 0, "R4 no step before eighth edge", bad, 0);
    @(negedge clk_i);
    chk(int'(cnt_o) == 1, "R4 step on eighth edge", int'(cnt_o), 1);
  endtask

  task automatic t_flag_fast();
    setup(1'b0, 1'b0, 2'd2, 6);
    clear_flag();
    wait_cnt(6);
    chk(flag_o == 1'b0, "R6 flag not early", int'(flag_o), 0);
    @(negedge clk_i);
    chk(flag_o == 1'b1 && int'(cnt_o) == 5, "R6 flag as count leaves match", int'(flag_o), 1);
    repeat (3) @(negedge clk_i);
    chk(flag_o == 1'b1, "R7 flag sticky", int'(flag_o), 1);
    clear_flag();
    chk(flag_o == 1'b0, "R7 flag cleared", int'(flag_o), 0);
    wait_cnt(6);
    flag_clr_i = 1'b1;
    @(negedge clk_i);
    flag_clr_i = 1'b0;
    chk(flag_o == 1'b1, "R7 match beats clear", int'(flag_o), 1);
  endtask

  task automatic t_flag_slow();
    int bad = 0;
    setup(1'b1, 1'b0, 2'd2, 6);
    clear_flag();
    wait_cnt(6);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk_i);
      if (flag_o) bad++;
    end
    chk(bad == 0, "R6 flag not before next tick (div 8)", bad, 0);
    @(negedge clk_i);
    chk(flag_o == 1'b1 && int'(cnt_o) == 5, "R6 flag on next tick (div 8)", int'(flag_o), 1);
  endtask

  task automatic t_buffer();
    setup(1'b0, 1'b0, 2'd2, 3);
    wait_cnt(0);
    wait_cnt(5);
    cmp_wr_i = 1'b1;
    cmp_wdata_i = W'(10);
    flag_clr_i = 1'b1;
    @(negedge clk_i);
    cmp_wr_i = 1'b0;
    flag_clr_i = 1'b0;
    wait_cnt(14);
    chk(flag_o == 1'b0, "R5 held value not active before top", int'(flag_o), 0);
    wait_cnt(9);
    chk(flag_o == 1'b1, "R5 new value active after top", int'(flag_o), 1);
  endtask

  task automatic t_duty(input logic [1:0] mode, input int cval, input int exp_hi, input string req);
    int hi = 0;
    setup(1'b0, 1'b0, mode, cval);
    repeat (4) @(negedge clk_i);
    for (int i = 0; i < 2 * TOPM; i++) begin
      if (pwm_o) hi++;
      @(negedge clk_i);
    end
    chk(hi == exp_hi, req, hi, exp_hi);
  endtask

  task automatic t_toggle();
    int hi = 0, chg = 0, mx = 0;
    logic prev;
    setup(1'b0, 1'b1, 2'd1, 5);
    repeat (4) @(negedge clk_i);
    prev = pwm_o;
    for (int i = 0; i < 40; i++) begin
      if (pwm_o) hi++;
      if (pwm_o != prev) chg++;
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
      prev = pwm_o;
      @(negedge clk_i);
    end
    chk(mx == 5, "R3 top from compare value", mx, 5);
    chk(hi == 20, "R12 toggle 50% duty", hi, 20);
    chk(chg == 4, "R12 toggle once per count period", chg, 4);
  endtask

  initial begin
    t_reset();
    t_triangle();
    t_prescale();
    t_flag_fast();
    t_flag_slow();
    t_buffer();
    t_duty(2'd2, 4, 8, "R9 non-inverted duty");
    t_duty(2'd3, 4, 2 * TOPM - 8, "R11 inverted duty");
    t_duty(2'd2, 0, 0, "R10 compare at bottom stays low");
    t_duty(2'd2, TOPM, 2 * TOPM, "R10 compare at top stays high");
    t_duty(2'd3, 0, 2 * TOPM, "R11 inverted bottom stays high");
    t_duty(2'd3, TOPM, 0, "R11 inverted top stays low");
    t_duty(2'd0, 4, 0, "R13 R8 mode 0 forced low");
    t_toggle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule